// File: doc/BRIEF.md
# Serial Receive Path with Flag-Carrying Character Queue

This block is the receive half of an asynchronous serial port. It samples the serial line on a strobe that runs at sixteen times the bit rate and rejects spurious start edges. It assembles characters of five to eight data bits, least significant bit first, and checks an optional parity bit and the first stop bit. Each finished character goes into a sixteen-entry queue. The queue holds four error flags next to each character, so every error stays attached to the character it belongs to.

The host side sees the character and flags at the head of the queue, the fill level, a summary error bit and a data-ready flag compared against a programmable threshold. It also gets one interrupt line, raised by the threshold or by an idle timeout, and an active-low request-to-send output that can throttle the far end when the queue is full. A line held low for a whole character is reported as a break: one zero character with its own flag. The queue can be emptied at once by a clear strobe. Bus decoding and the transmitter belong to other blocks.

The receiver is a six-state machine: RX_IDLE waits for a low sample on a tick. RX_START counts to mid-bit and either confirms the start (to RX_DATA) or rejects it (back to RX_IDLE). RX_DATA samples one bit per sixteen ticks and moves to RX_PARITY after the last bit when parity is on, or else to RX_STOP. RX_PARITY samples one bit and moves to RX_STOP. RX_STOP samples the stop bit and stores the character. It goes to RX_BRKWAIT if the whole frame was low, or else to RX_IDLE. RX_BRKWAIT holds until the line is seen high on a tick, then returns to RX_IDLE.

Top module: `uart_rx_fifo_core`

## Requirements
- R1: A low line seen in RX_IDLE starts a frame only if the line is still low at the 8th tick after detection (mid-bit). Otherwise nothing is stored and the receiver returns to idle.
- R2: Data bits arrive least significant bit first. `len_code` 00/01/10/11 selects 5/6/7/8 data bits, and the unused upper bits of a stored character read as zero.
- R3: `par_mode` 00 = no parity bit, 01 = even, 10 = odd, 11 = parity bit expected to be 1. The parity flag (`head_err[1]`) is set when the received parity bit differs from the expected one.
- R4: A low first stop bit sets the framing flag (`head_err[2]`) of that character. The character itself is still stored.
- R5: A frame whose data bits, parity bit and stop bit are all low stores exactly one 0x00 entry with only the break flag (`head_err[3]`) set. Nothing more is stored until the line has returned high and a valid start bit follows.
- R6: A character completing while 16 entries are held is discarded and the level stays 16. The overrun flag (`head_err[0]`) is set on the next character that is stored.
- R7: `head_data`/`head_err` show the oldest entry. `err_any` is high exactly while at least one held entry has a nonzero flag, and is low when the queue is empty.
- R8: `thr_code` 000/001/010/011/100 sets a threshold of 1/2/4/6/8 entries, and any other code means 8. `data_rdy` is high while `rx_level` is at or above the threshold.
- R9: `rx_irq` sets in the cycle after `data_rdy` rises and clears on a `stat_rd` pulse. A set condition in the same cycle wins over the clear.
- R10: `rx_irq` also sets when the queue is non-empty and no character has been stored for 32 bit times (512 ticks).
- R11: `fifo_clr` brings `rx_level` to 0 and `err_any` low in the next cycle. It does not disturb a frame in progress.
- R12: With `auto_rts_en` high, `rts_n` is high exactly while 16 entries are held. Otherwise `rts_n` is the inverse of `rts_ctrl`.
- R13: A `rd_pop` pulse on a non-empty queue removes the head entry, and the next entry appears at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | One-cycle strobe at 16x bit rate |
| len_code | input | 2 | Data bit count select |
| par_mode | input | 2 | Parity mode select |
| thr_code | input | 3 | Data-ready threshold code |
| fifo_clr | input | 1 | Empty the queue |
| rd_pop | input | 1 | Remove head entry |
| stat_rd | input | 1 | Status read, clears interrupt |
| auto_rts_en | input | 1 | Full-driven request-to-send enable |
| rts_ctrl | input | 1 | Manual request-to-send level (1 = assert) |
| head_data | output | 8 | Character at queue head |
| head_err | output | 4 | Head flags {break, framing, parity, overrun} |
| rx_level | output | 5 | Entries held (0 to 16) |
| err_any | output | 1 | Some held entry carries a flag |
| data_rdy | output | 1 | Level at or above threshold |
| rx_irq | output | 1 | Receive interrupt |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
On every cycle the assertions check the level bookkeeping: a clear empties the queue, a lone pop lowers the level by one, and the level never goes past sixteen. They also check that an empty queue shows no error summary, that a rising data-ready flag raises the interrupt, and that automatic flow control holds the request line off when the queue is full. The bench's scenarios have to show the serial-side behaviour. That covers rejection of a short start pulse, bit order and upper-bit masking for each length, each parity mode, framing and break handling with the wait for the line to return high, overrun flag placement, and the 512-tick idle timeout.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_BRKWAIT
    } rx_state_t;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ODD   = 2'b10,
        PAR_STICK = 2'b11
    } par_mode_t;

    // Bit 3 break, bit 2 framing, bit 1 parity, bit 0 overrun
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
        logic ovr;
    } rx_flags_t;

    function automatic logic [4:0] thr_bytes(input logic [2:0] code);
        logic [4:0] n;
        unique case (code)
            3'b000:  n = 5'd1;
            3'b001:  n = 5'd2;
            3'b010:  n = 5'd4;
            3'b011:  n = 5'd6;
            default: n = 5'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    input  logic          tick,
    input  logic [1:0]    len_code,
    input  par_mode_t     par_mode,
    output logic          push,
    output logic [DW-1:0] push_data,
    output rx_flags_t     push_flags
);

    localparam int CNTW = $clog2(OSR);
    localparam int IW   = $clog2(DW);
    localparam logic [CNTW-1:0] MID_CNT = CNTW'(OSR / 2 - 1);
    localparam logic [CNTW-1:0] END_CNT = CNTW'(OSR - 1);

    rx_state_t      st_q, st_d;
    logic           rxd_m, rxd_s;
    logic [CNTW-1:0] cnt_q;
    logic [IW-1:0]  idx_q;
    logic [DW-1:0]  shf_q;
    logic           par_acc_q, par_err_q, zero_q;
    logic           sample, last_bit, exp_par, is_break;

    // Two-stage synchronizer, idle high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            rxd_m <= rxd;
            rxd_s <= rxd_m;
        end
    end

    assign sample = tick &&
        (((st_q == RX_START) && (cnt_q == MID_CNT)) ||
         (((st_q == RX_DATA) || (st_q == RX_PARITY) || (st_q == RX_STOP)) &&
          (cnt_q == END_CNT)));

    assign last_bit = (idx_q == (IW'(4) + IW'(len_code)));

    always_comb begin
        unique case (par_mode)
            PAR_EVEN: exp_par = par_acc_q;
            PAR_ODD:  exp_par = ~par_acc_q;
            default:  exp_par = 1'b1;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:    if (tick && !rxd_s) st_d = RX_START;
            RX_START:   if (sample) st_d = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:    if (sample && last_bit)
                            st_d = (par_mode != PAR_NONE) ? RX_PARITY : RX_STOP;
            RX_PARITY:  if (sample) st_d = RX_STOP;
            RX_STOP:    if (sample) st_d = (!rxd_s && zero_q) ? RX_BRKWAIT : RX_IDLE;
            RX_BRKWAIT: if (tick && rxd_s) st_d = RX_IDLE;
            default:    st_d = RX_IDLE;
        endcase
    end

    // Datapath: tick counter, shift register, parity and zero tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            shf_q     <= '0;
            par_acc_q <= 1'b0;
            par_err_q <= 1'b0;
            zero_q    <= 1'b0;
        end else begin
            if ((st_q != st_d) || (st_q == RX_IDLE) || (st_q == RX_BRKWAIT))
                cnt_q <= '0;
            else if (tick)
                cnt_q <= (cnt_q == END_CNT) ? '0 : cnt_q + 1'b1;

            if ((st_q == RX_START) && sample && !rxd_s) begin
                shf_q     <= '0;
                idx_q     <= '0;
                par_acc_q <= 1'b0;
                par_err_q <= 1'b0;
                zero_q    <= 1'b1;
            end else if ((st_q == RX_DATA) && sample) begin
                shf_q[idx_q] <= rxd_s;
                idx_q        <= idx_q + 1'b1;
                par_acc_q    <= par_acc_q ^ rxd_s;
                zero_q       <= zero_q & ~rxd_s;
            end else if ((st_q == RX_PARITY) && sample) begin
                par_err_q <= (rxd_s != exp_par);
                zero_q    <= zero_q & ~rxd_s;
            end
        end
    end

    // Outputs
    always_comb begin
        is_break       = !rxd_s && zero_q;
        push           = sample && (st_q == RX_STOP);
        push_data      = is_break ? '0 : shf_q;
        push_flags.brk = is_break;
        push_flags.frm = !rxd_s && !is_break;
        push_flags.par = par_err_q && !is_break;
        push_flags.ovr = 1'b0;
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  rx_flags_t     push_flags,
    input  logic          pop,
    input  logic          clr,
    output logic [DW-1:0] head_data,
    output rx_flags_t     head_flags,
    output logic [LW-1:0] level,
    output logic          err_any
);

    logic [DW-1:0]  data_mem [DEPTH];
    rx_flags_t      flag_mem [DEPTH];
    logic [AW-1:0]  wptr_q, rptr_q;
    logic [LW-1:0]  level_q, errs_q;
    logic           ovr_pend_q;
    logic           full, accept, do_pop, in_err, head_bad;
    rx_flags_t      in_flags;

    assign full     = (level_q == LW'(DEPTH));
    assign accept   = push && !full;
    assign do_pop   = pop && (level_q != '0);
    assign in_flags = push_flags | rx_flags_t'({3'b000, ovr_pend_q});
    assign in_err   = |in_flags;
    assign head_bad = |flag_mem[rptr_q];

    always_ff @(posedge clk) begin
        if (accept && !clr) begin
            data_mem[wptr_q] <= push_data;
            flag_mem[wptr_q] <= in_flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q     <= '0;
            rptr_q     <= '0;
            level_q    <= '0;
            errs_q     <= '0;
            ovr_pend_q <= 1'b0;
        end else begin
            if (push && full)  ovr_pend_q <= 1'b1;
            else if (accept && !clr) ovr_pend_q <= 1'b0;

            if (clr) begin
                wptr_q  <= '0;
                rptr_q  <= '0;
                level_q <= '0;
                errs_q  <= '0;
            end else begin
                if (accept) wptr_q <= wptr_q + 1'b1;
                if (do_pop) rptr_q <= rptr_q + 1'b1;
                level_q <= level_q + LW'(accept) - LW'(do_pop);
                errs_q  <= errs_q + LW'(accept && in_err) - LW'(do_pop && head_bad);
            end
        end
    end

    assign head_data  = data_mem[rptr_q];
    assign head_flags = flag_mem[rptr_q];
    assign level      = level_q;
    assign err_any    = (errs_q != '0);

endmodule

// File: rtl/uart_rx_irq.sv
module uart_rx_irq
    import uart_rx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int TMO_BITS = 32,
    parameter int LW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          push,
    input  logic          stat_rd,
    input  logic [2:0]    thr_code,
    input  logic [LW-1:0] level,
    output logic          data_rdy,
    output logic          irq
);

    localparam int TMO_TICKS = TMO_BITS * OSR;
    localparam int TW        = $clog2(TMO_TICKS + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TMO_TICKS - 1);

    logic [TW-1:0] tmo_q;
    logic          rdy_q, tmo_hit, rdy_rise;

    assign data_rdy = (level >= LW'(thr_bytes(thr_code)));
    assign rdy_rise = data_rdy && !rdy_q;
    assign tmo_hit  = tick && (level != '0) && !push && (tmo_q == TMO_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_q <= '0;
            rdy_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            rdy_q <= data_rdy;
            if ((level == '0) || push)
                tmo_q <= '0;
            else if (tick && (tmo_q != TW'(TMO_TICKS)))
                tmo_q <= tmo_q + 1'b1;

            if (rdy_rise || tmo_hit) irq <= 1'b1;
            else if (stat_rd)        irq <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_fifo_core.sv
module uart_rx_fifo_core
    import uart_rx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int DW       = 8,
    parameter int DEPTH    = 16,
    parameter int TMO_BITS = 32,
    localparam int LW      = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd_in,
    input  logic          os_tick,
    input  logic [1:0]    len_code,
    input  logic [1:0]    par_mode,
    input  logic [2:0]    thr_code,
    input  logic          fifo_clr,
    input  logic          rd_pop,
    input  logic          stat_rd,
    input  logic          auto_rts_en,
    input  logic          rts_ctrl,
    output logic [DW-1:0] head_data,
    output logic [3:0]    head_err,
    output logic [LW-1:0] rx_level,
    output logic          err_any,
    output logic          data_rdy,
    output logic          rx_irq,
    output logic          rts_n
);

    logic          push_w;
    logic [DW-1:0] push_data_w;
    rx_flags_t     push_flags_w, head_flags_w;

    uart_rx_deser #(.OSR(OSR), .DW(DW)) deser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd_in),
        .tick       (os_tick),
        .len_code   (len_code),
        .par_mode   (par_mode_t'(par_mode)),
        .push       (push_w),
        .push_data  (push_data_w),
        .push_flags (push_flags_w)
    );

    uart_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) fifo_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push_w),
        .push_data  (push_data_w),
        .push_flags (push_flags_w),
        .pop        (rd_pop),
        .clr        (fifo_clr),
        .head_data  (head_data),
        .head_flags (head_flags_w),
        .level      (rx_level),
        .err_any    (err_any)
    );

    uart_rx_irq #(.OSR(OSR), .TMO_BITS(TMO_BITS), .LW(LW)) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .push     (push_w),
        .stat_rd  (stat_rd),
        .thr_code (thr_code),
        .level    (rx_level),
        .data_rdy (data_rdy),
        .irq      (rx_irq)
    );

    assign head_err = head_flags_w;
    assign rts_n    = auto_rts_en ? (rx_level == LW'(DEPTH)) : ~rts_ctrl;

endmodule

// File: rtl/uart_rx_fifo_core_chk.sv
module uart_rx_fifo_core_chk #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fifo_clr,
    input logic          rd_pop,
    input logic          push_w,
    input logic          data_rdy,
    input logic          rx_irq,
    input logic          err_any,
    input logic          auto_rts_en,
    input logic          rts_n,
    input logic [LW-1:0] rx_level
);

    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (rx_level == '0));

    a_r13_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && !fifo_clr && !push_w && (rx_level != '0))
        |=> (rx_level == $past(rx_level) - 1'b1));

    a_r6_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LW'(DEPTH));

    a_r7_empty_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> !err_any);

    a_r9_rise_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_rdy) |=> rx_irq);

    a_r12_full_holds_rts: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && (rx_level == LW'(DEPTH))) |-> rts_n);

endmodule

bind uart_rx_fifo_core uart_rx_fifo_core_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fifo_clr    (fifo_clr),
    .rd_pop      (rd_pop),
    .push_w      (push_w),
    .data_rdy    (data_rdy),
    .rx_irq      (rx_irq),
    .err_any     (err_any),
    .auto_rts_en (auto_rts_en),
    .rts_n       (rts_n),
    .rx_level    (rx_level)
);

// File: tb/uart_rx_fifo_core_tb_top.sv
`timescale 1ns/1ps
module uart_rx_fifo_core_tb_top;

    localparam int BIT_CYC = 64;   // 16 ticks of 4 cycles
    localparam int NVEC    = 7;
    // {len[1:0], pmode[1:0], data[7:0], good_par, stop, exp_data[7:0], exp_flags[3:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {2'b11, 2'b00, 8'hA5, 1'b1, 1'b1, 8'hA5, 4'b0000},
        {2'b00, 2'b00, 8'hFF, 1'b1, 1'b1, 8'h1F, 4'b0000},
        {2'b10, 2'b01, 8'h35, 1'b1, 1'b1, 8'h35, 4'b0000},
        {2'b11, 2'b10, 8'h3C, 1'b0, 1'b1, 8'h3C, 4'b0010},
        {2'b01, 2'b11, 8'h2A, 1'b0, 1'b1, 8'h2A, 4'b0010},
        {2'b11, 2'b00, 8'h81, 1'b1, 1'b0, 8'h81, 4'b0100},
        {2'b01, 2'b10, 8'h15, 1'b1, 1'b1, 8'h15, 4'b0000}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd_in = 1'b1;
    logic       os_tick = 1'b0;
    logic [1:0] len_code = 2'b11;
    logic [1:0] par_mode = 2'b00;
    logic [2:0] thr_code = 3'b000;
    logic       fifo_clr = 1'b0, rd_pop = 1'b0, stat_rd = 1'b0;
    logic       auto_rts_en = 1'b0, rts_ctrl = 1'b1;
    logic [7:0] head_data;
    logic [3:0] head_err;
    logic [4:0] rx_level;
    logic       err_any, data_rdy, rx_irq, rts_n;
    logic [1:0] div_q = 2'd0;
    int         checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        div_q   <= div_q + 2'd1;
        os_tick <= (div_q == 2'd3);
    end

    uart_rx_fifo_core dut_i (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic v);
        rxd_in = v;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    function automatic logic exp_parity(input logic [7:0] d, input int n, input logic [1:0] pm);
        logic x = 1'b0;
        for (int i = 0; i < n; i++) x ^= d[i];
        case (pm)
            2'b01:   return x;
            2'b10:   return ~x;
            default: return 1'b1;
        endcase
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic good, input logic stopb);
        int n = 5 + int'(len_code);
        send_bit(1'b0);
        for (int i = 0; i < n; i++) send_bit(d[i]);
        if (par_mode != 2'b00) begin
            logic p = exp_parity(d, n, par_mode);
            send_bit(good ? p : ~p);
        end
        send_bit(stopb);
        send_bit(1'b1);
    endtask

    task automatic pulse_pop();
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
    endtask

    task automatic pulse_stat();
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * 4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Reset state
        check("R13 reset level", rx_level, 0);
        check("R9 reset irq", rx_irq, 0);
        check("R7 reset err_any", err_any, 0);
        check("R12 manual rts asserted", rts_n, 0);
        rts_ctrl = 1'b0;
        @(negedge clk);
        check("R12 manual rts released", rts_n, 1);
        rts_ctrl = 1'b1;

        // Table-driven frames
        for (int v = 0; v < NVEC; v++) begin
            logic [25:0] e = VEC[v];
            len_code = e[25:24];
            par_mode = e[23:22];
            send_frame(e[21:14], e[13], e[12]);
            check("R2 R3 R4 level after frame", rx_level, 1);
            check("R2 R3 head data", head_data, e[11:4]);
            check("R3 R4 head flags", head_err, e[3:0]);
            check("R7 err summary", err_any, |e[3:0]);
            pulse_pop();
            check("R13 pop empties", rx_level, 0);
        end

        // False start: 4-tick low pulse
        len_code = 2'b11; par_mode = 2'b00;
        rxd_in = 1'b0; wait_ticks(4);
        rxd_in = 1'b1; wait_ticks(40);
        check("R1 false start ignored", rx_level, 0);

        // Break
        send_bit(1'b0);
        repeat (11) send_bit(1'b0);
        check("R5 break stores one entry", rx_level, 1);
        check("R5 break data zero", head_data, 0);
        check("R5 break flag only", head_err, 4'b1000);
        check("R7 break raises summary", err_any, 1);
        repeat (10) send_bit(1'b0);
        check("R5 held low adds nothing", rx_level, 1);
        send_bit(1'b1); send_bit(1'b1);
        send_frame(8'h5A, 1'b1, 1'b1);
        check("R5 start after break accepted", rx_level, 2);
        check("R7 head still break entry", head_err, 4'b1000);

        // Clear
        @(negedge clk) fifo_clr = 1'b1;
        @(negedge clk) fifo_clr = 1'b0;
        check("R11 clear empties", rx_level, 0);
        check("R11 clear drops summary", err_any, 0);
        send_frame(8'hC3, 1'b1, 1'b1);
        check("R11 next char at head", head_data, 8'hC3);
        pulse_pop();

        // Threshold and interrupt
        thr_code = 3'b001;
        pulse_stat();
        check("R9 stat read clears", rx_irq, 0);
        send_frame(8'h11, 1'b1, 1'b1);
        check("R8 below threshold 2", data_rdy, 0);
        check("R9 no irq below threshold", rx_irq, 0);
        send_frame(8'h22, 1'b1, 1'b1);
        check("R8 at threshold 2", data_rdy, 1);
        check("R9 irq on threshold", rx_irq, 1);
        pulse_stat();
        check("R9 irq cleared by read", rx_irq, 0);
        thr_code = 3'b010;
        @(negedge clk);
        check("R8 threshold 4 not met", data_rdy, 0);
        thr_code = 3'b111;
        @(negedge clk);
        check("R8 reserved code means 8", data_rdy, 0);
        pulse_pop();
        check("R13 next head after pop", head_data, 8'h22);
        pulse_pop();

        // Idle timeout
        thr_code = 3'b100;
        pulse_stat();
        send_frame(8'h33, 1'b1, 1'b1);
        wait_ticks(300);
        check("R10 no timeout yet", rx_irq, 0);
        wait_ticks(300);
        check("R10 timeout irq", rx_irq, 1);
        pulse_stat();
        pulse_pop();

        // Overrun and automatic flow control
        auto_rts_en = 1'b1;
        for (int i = 0; i < 16; i++) send_frame(8'(i + 1), 1'b1, 1'b1);
        check("R6 queue full", rx_level, 16);
        check("R12 auto rts off when full", rts_n, 1);
        send_frame(8'hEE, 1'b1, 1'b1);
        check("R6 lost char keeps level", rx_level, 16);
        check("R6 head unchanged", head_data, 8'h01);
        check("R7 no summary before overrun stored", err_any, 0);
        pulse_pop();
        check("R12 auto rts on below full", rts_n, 0);
        for (int i = 0; i < 15; i++) pulse_pop();
        check("R13 drained", rx_level, 0);
        send_frame(8'h77, 1'b1, 1'b1);
        check("R6 next char data", head_data, 8'h77);
        check("R6 overrun flag on next char", head_err, 4'b0001);
        check("R7 overrun summary", err_any, 1);
        pulse_pop();
        send_frame(8'h78, 1'b1, 1'b1);
        check("R6 overrun flag not repeated", head_err, 4'b0000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule